// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a clocked model of the command front end of a byte-wide parallel NOR flash. The chip-select, output-enable and write-enable strobes arrive asynchronously and are all active low. Two-flop synchronizers bring them onto a fast system clock. Edges are then detected on the synchronized copies. Every bus cycle is classified as standby, output-disable, read or write. Each completed write hands its captured address and byte to a sequence tracker. That tracker follows the multi-write unlock dialogues held in a command latch, which has no address in the memory map.

When a dialogue completes, one request is raised on a valid/ready output stream toward the internal algorithm engine. A request is one of program, sector erase, chip erase or return-to-read, and it carries the captured address and byte. The fields are held steady for as long as `req_valid` is high and `req_ready` is low. A transfer happens on any clock edge where both are high. While a request waits, the decoder drops every further host write, so back-pressure never reorders or merges requests.

The host must hold the address stable for at least three system clocks after the later of the two strobe falls. It must hold the data stable for three clocks after the earlier of the two strobe rises.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `req_valid` is 0 and `rd_mode` is 1, so the array can be read without any command.
- R2: `bus_op` encodes the synchronized strobes as follows. 0 (standby) when chip-select is high. 3 (write) when chip-select is low, write-enable is low and output-enable is high. 2 (read) when chip-select is low, output-enable is low and write-enable is high. 1 (output disabled) for the other two cases with chip-select low.
- R3: `dout_en` is 1 only while `bus_op` is read. In standby it is 0 whatever output-enable does.
- R4: A write's address is taken from `addr` when the later of chip-select and write-enable falls.
- R5: A write's byte is taken from `din` when the earlier of chip-select and write-enable rises.
- R6: The writes 555h/AAh, 2AAh/55h, 555h/A0h, then any address A with byte D, raise a request with kind 0 (program), `req_addr`=A and `req_data`=D. Command addresses compare only the low 11 address bits.
- R7: The writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then any address A with byte 30h, raise kind 1 (sector erase) with `req_addr`=A. `req_sector` equals the top three bits of A.
- R8: The same five writes followed by 555h/10h raise kind 2 (chip erase).
- R9: Byte F0h raises kind 3 (return to read) in two cases: written at any address while idle, or written after the two unlock writes. `rd_mode` is 1 afterwards.
- R10: A write that breaks an expected sequence returns the decoder to idle (`rd_mode`=1) without raising a request. A following correct sequence is then accepted.
- R11: While `req_valid` is 1 and `req_ready` is 0, the request fields are stable. A transfer clears `req_valid`. Writes made while a request waits are discarded.
- R12: `rd_mode` is 0 while a sequence is partly entered.
- R13: Raising chip-select while a request waits neither drops nor changes that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Host address bus |
| din | input | DATA_W | Host write data |
| bus_op | output | 2 | Classified bus cycle (R2 encoding) |
| dout_en | output | 1 | Data output drive enable |
| rd_mode | output | 1 | Decoder idle in array-read mode |
| req_valid | output | 1 | Request stream valid |
| req_ready | input | 1 | Request stream ready from the engine |
| req_kind | output | 2 | 0 program, 1 sector erase, 2 chip erase, 3 return to read |
| req_addr | output | ADDR_W | Captured address |
| req_data | output | DATA_W | Captured byte |
| req_sector | output | SECTOR_BITS | Sector index, top address bits |

## Verification
Two things can meet in one cycle: the end of a host write and the acceptance of a waiting request. They can also coincide with that request's hand-off on the stream. The bench provokes this by holding `req_ready` low while a request waits and writing a return-to-read byte during the wait. It then releases ready. The result is judged at the ports: the held request must be delivered unchanged, and no second request may follow. The bench also sweeps every strobe combination and every sector number, and moves the address and data buses between the two strobe edges in both orders.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [1:0] {
    OP_STANDBY = 2'd0,
    OP_OUTDIS  = 2'd1,
    OP_READ    = 2'd2,
    OP_WRITE   = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    RQ_PROGRAM = 2'd0,
    RQ_SECTOR  = 2'd1,
    RQ_CHIP    = 2'd2,
    RQ_RESET   = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PSET, S_ESET, S_EU1, S_EU2
  } seq_state_e;
endpackage

// File: rtl/fcd_sync.sv
module fcd_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_ONE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= {W{RST_ONE}};
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              oe_s,
  input  logic              we_s,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [1:0]        bus_op,
  output logic              dout_en,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic    wr_act, act_q, wr_start, wr_end;
  bus_op_e op_now;

  // Write window opens at the later strobe fall, closes at the earlier rise.
  assign wr_act   = ~ce_s & ~we_s & oe_s;
  assign wr_start = wr_act & ~act_q;
  assign wr_end   = ~wr_act & act_q;

  always_comb begin
    if (ce_s)                op_now = OP_STANDBY;
    else if (oe_s && !we_s)  op_now = OP_WRITE;
    else if (!oe_s && we_s)  op_now = OP_READ;
    else                     op_now = OP_OUTDIS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      bus_op  <= OP_STANDBY;
      dout_en <= 1'b0;
    end else begin
      act_q   <= wr_act;
      wr_stb  <= wr_end;
      if (wr_start) wr_addr <= addr;
      if (wr_end)   wr_data <= din;
      bus_op  <= op_now;
      dout_en <= ~ce_s & ~oe_s & we_s;
    end
  end

  a_r5_strobe_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(act_q));
  a_r4_addr_held_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && wr_act) |=> $stable(wr_addr));
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CMD_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              rd_mode
);
  localparam logic [CMD_AW-1:0] A_1ST = CMD_AW'(11'h555);
  localparam logic [CMD_AW-1:0] A_2ND = CMD_AW'(11'h2AA);
  localparam logic [DATA_W-1:0] D_AA  = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] D_55  = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] D_PRG = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] D_ERS = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] D_CHP = DATA_W'(8'h10);
  localparam logic [DATA_W-1:0] D_SEC = DATA_W'(8'h30);
  localparam logic [DATA_W-1:0] D_RST = DATA_W'(8'hF0);

  seq_state_e state, state_nx;
  logic       accept, issue, is_a1, is_a2;
  req_kind_e  kind_nx;

  assign accept = wr_stb & ~req_valid;
  assign is_a1  = (wr_addr[CMD_AW-1:0] == A_1ST);
  assign is_a2  = (wr_addr[CMD_AW-1:0] == A_2ND);

  always_comb begin
    state_nx = S_IDLE;
    issue    = 1'b0;
    kind_nx  = RQ_RESET;
    unique case (state)
      S_IDLE: begin
        if (wr_data == D_RST) issue = 1'b1;
        else if (is_a1 && wr_data == D_AA) state_nx = S_U1;
      end
      S_U1:  if (is_a2 && wr_data == D_55) state_nx = S_U2;
      S_U2: begin
        if (is_a1 && wr_data == D_PRG)      state_nx = S_PSET;
        else if (is_a1 && wr_data == D_ERS) state_nx = S_ESET;
        else if (wr_data == D_RST)          issue = 1'b1;
      end
      S_PSET: begin
        issue   = 1'b1;
        kind_nx = RQ_PROGRAM;
      end
      S_ESET: if (is_a1 && wr_data == D_AA) state_nx = S_EU1;
      S_EU1:  if (is_a2 && wr_data == D_55) state_nx = S_EU2;
      S_EU2: begin
        if (is_a1 && wr_data == D_CHP) begin
          issue = 1'b1; kind_nx = RQ_CHIP;
        end else if (wr_data == D_SEC) begin
          issue = 1'b1; kind_nx = RQ_SECTOR;
        end
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      req_valid <= 1'b0;
      req_kind  <= RQ_RESET;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (accept) begin
        state <= state_nx;
        if (issue) begin
          req_valid <= 1'b1;
          req_kind  <= kind_nx;
          req_addr  <= wr_addr;
          req_data  <= wr_data;
        end
      end
    end
  end

  assign rd_mode = (state == S_IDLE);

  a_r11_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_kind)
                                   && $stable(req_addr) && $stable(req_data)));
  a_r11_clear_on_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);
  a_r6_request_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(wr_stb));
  a_r11_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $stable(state));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int CMD_AW      = 11,
  parameter int SECTOR_BITS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   oe_n,
  input  logic                   we_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      din,
  output logic [1:0]             bus_op,
  output logic                   dout_en,
  output logic                   rd_mode,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [1:0]             req_kind,
  output logic [ADDR_W-1:0]      req_addr,
  output logic [DATA_W-1:0]      req_data,
  output logic [SECTOR_BITS-1:0] req_sector
);
  logic [2:0]        strobes_s;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  fcd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ce_n, oe_n, we_n}), .q(strobes_s)
  );

  fcd_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .ce_s(strobes_s[2]), .oe_s(strobes_s[1]), .we_s(strobes_s[0]),
    .addr(addr), .din(din),
    .bus_op(bus_op), .dout_en(dout_en),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_AW(CMD_AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_ready(req_ready), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data), .rd_mode(rd_mode)
  );

  assign req_sector = req_addr[ADDR_W-1 -: SECTOR_BITS];

  a_r3_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (bus_op == OP_READ));
  a_r3_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == OP_STANDBY) |-> !dout_en);
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int AW = 19;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          req_ready = 1'b0;
  logic [1:0]    bus_op, req_kind;
  logic          dout_en, rd_mode, req_valid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [2:0]    req_sector;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .bus_op(bus_op), .dout_en(dout_en),
    .rd_mode(rd_mode), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .req_sector(req_sector)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; din = d;
    ce_n = 1'b0; idle(4);
    we_n = 1'b0; idle(5);
    we_n = 1'b1; idle(5);
    ce_n = 1'b1; idle(5);
  endtask

  // we_first=1: WE falls first, CE falls last; CE rises first.
  // we_first=0: CE falls first, WE falls last; WE rises first.
  task automatic wr_split(input bit we_first, input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = ~a; din = ~d;
    if (we_first) we_n = 1'b0; else ce_n = 1'b0;
    idle(5);
    addr = a;
    if (we_first) ce_n = 1'b0; else we_n = 1'b0;
    idle(5);
    addr = a ^ 19'h7FFFF; din = d;
    idle(4);
    if (we_first) ce_n = 1'b1; else we_n = 1'b1;
    idle(5);
    din = d ^ 8'hFF;
    if (we_first) we_n = 1'b1; else ce_n = 1'b1;
    idle(5);
  endtask

  task automatic unlock();
    wr(19'h555, 8'hAA);
    wr(19'h2AA, 8'h55);
  endtask

  task automatic take();
    req_ready = 1'b1; @(negedge clk);
    req_ready = 1'b0; idle(2);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    chk("R1 req_valid", req_valid, 0);
    chk("R1 rd_mode", rd_mode, 1);
    rst_n = 1'b1;
    idle(3);
    chk("R1 rd_mode after release", rd_mode, 1);

    // R2, R3: sweep every strobe combination
    for (int i = 0; i < 16; i++) begin
      logic c, o, w;
      logic [1:0] e_op;
      {c, o, w} = 3'(i % 8);
      ce_n = c; oe_n = o; we_n = w;
      idle(5);
      if (c) e_op = 2'd0;
      else if (o && !w) e_op = 2'd3;
      else if (!o && w) e_op = 2'd2;
      else e_op = 2'd1;
      chk("R2 bus_op", bus_op, e_op);
      chk("R3 dout_en", dout_en, (e_op == 2'd2));
    end
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; idle(6);
    chk("R9 idle after sweep", rd_mode, 1);

    // R6, R12, R11: program sweep with back-pressure
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] ta;
      logic [DW-1:0] td;
      ta = AW'(i * 32'h9A31 + 7);
      td = DW'(i * 37 + 5);
      wr(19'h555, 8'hAA);
      chk("R12 mid-sequence rd_mode", rd_mode, 0);
      wr(19'h2AA, 8'h55);
      wr(19'h555, 8'hA0);
      chk("R12 after setup rd_mode", rd_mode, 0);
      wr(ta, td);
      chk("R6 valid", req_valid, 1);
      chk("R6 kind", req_kind, 0);
      chk("R6 addr", req_addr, ta);
      chk("R6 data", req_data, td);
      idle(7);
      chk("R11 still held", {req_valid, req_addr, req_data}, {1'b1, ta, td});
      take();
      chk("R11 cleared", req_valid, 0);
    end

    // R4, R5: strobe order variants
    for (int v = 0; v < 2; v++) begin
      unlock();
      wr(19'h555, 8'hA0);
      wr_split(v[0], 19'h4C3A1, 8'h6B);
      chk("R4 captured addr", req_addr, 19'h4C3A1);
      chk("R5 captured data", req_data, 8'h6B);
      take();
    end

    // R7: every sector
    for (int s = 0; s < 8; s++) begin
      logic [AW-1:0] sa;
      sa = AW'((s << 16) | 16'h1234);
      unlock();
      wr(19'h555, 8'h80);
      unlock();
      wr(sa, 8'h30);
      chk("R7 kind", req_kind, 1);
      chk("R7 sector", req_sector, s);
      chk("R7 addr", req_addr, sa);
      take();
    end

    // R8: chip erase
    unlock(); wr(19'h555, 8'h80); unlock(); wr(19'h555, 8'h10);
    chk("R8 valid", req_valid, 1);
    chk("R8 kind", req_kind, 2);
    take();

    // R9: return to read, idle and after unlock
    wr(19'h12345, 8'hF0);
    chk("R9 kind idle", {req_valid, req_kind}, 3'b111);
    chk("R9 rd_mode", rd_mode, 1);
    take();
    unlock(); wr(19'h555, 8'hF0);
    chk("R9 kind after unlock", {req_valid, req_kind}, 3'b111);
    chk("R9 rd_mode after unlock", rd_mode, 1);
    take();

    // R10: broken sequences
    wr(19'h555, 8'hAB);
    chk("R10 bad first data", {req_valid, rd_mode}, 2'b01);
    wr(19'h555, 8'hAA); wr(19'h2AB, 8'h55);
    chk("R10 bad second addr", {req_valid, rd_mode}, 2'b01);
    unlock(); wr(19'h555, 8'h90);
    chk("R10 bad setup", {req_valid, rd_mode}, 2'b01);
    unlock(); wr(19'h555, 8'h80); unlock(); wr(19'h555, 8'h20);
    chk("R10 bad confirm", {req_valid, rd_mode}, 2'b01);
    unlock(); wr(19'h555, 8'hA0); wr(19'h00042, 8'h99);
    chk("R10 recovery program", {req_valid, req_kind, req_data}, {1'b1, 2'd0, 8'h99});

    // R13: standby with pending request
    ce_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      oe_n = ~oe_n; idle(4);
    end
    oe_n = 1'b1;
    chk("R13 kept", {req_valid, req_kind, req_addr, req_data}, {1'b1, 2'd0, 19'h00042, 8'h99});
    chk("R3 standby no drive", dout_en, 0);

    // R11: write while pending is discarded
    wr(19'h0, 8'hF0);
    chk("R11 pending unchanged", {req_valid, req_kind, req_data}, {1'b1, 2'd0, 8'h99});
    take();
    idle(10);
    chk("R11 discarded write", req_valid, 0);
    chk("R11 state idle", rd_mode, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule